// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Controller

The controller collects level-sensitive interrupt lines and delivers them to up to four CPUs. Each CPU has one IRQ output and one FIQ output. The lowest-numbered sources are private to each CPU. Every CPU drives its own copy of those lines, and a private source only ever reaches the CPU that owns that copy. All higher-numbered sources are shared. A per-source routing register decides which CPUs receive a shared source as IRQ and which receive it as FIQ.

Every source is gated twice before it reaches a CPU:
- A global enable bit, common to all CPUs, is set or cleared by writing the source number to one of two global registers.
- A per-CPU mask bit is set or cleared by writing the source number to one of two registers in a per-CPU window.

A single simple register bus reaches the controller. Each request carries the identifier of the issuing CPU as sideband, so one per-CPU address window always resolves to the caller's own mask and acknowledge registers. Reading the acknowledge register returns the number of the caller's highest-priority deliverable IRQ source, or a spurious code when none is deliverable.

Top module: `dgic_top`

## Requirements
- R1: After reset, every source is globally disabled and masked on every CPU, and every routing register is zero. Even with all input lines high, every irq_o and fiq_o bit is 0 and every acknowledge read returns 1023.
- R2: In the global window (req_win_i=0), a write to offset 0x030 enables source req_wdata_i, and a write to offset 0x034 disables it. A write whose full 32-bit value is not below N_SRC changes nothing.
- R3: In the per-CPU window (req_win_i=1), a write to offset 0x048 masks source req_wdata_i for CPU req_cpu_i only, and a write to offset 0x04C unmasks it for that CPU only. A write whose value is not below N_SRC changes nothing.
- R4: Global offset 0x100+4*n is the routing register of source n. Bits [N_CPU-1:0] select the IRQ targets and bits [8+N_CPU-1:8] the FIQ targets; bit c and bit c+8 belong to CPU c. The register reads back with all other bits 0.
- R5: Sources 0 to N_PCPU-1 are private. CPU c sees source s through pcpu_lvl_i[c*N_PCPU+s]. Such a source raises only irq_o[c], whatever its routing register holds, and never raises FIQ.
- R6: irq_o[c] is the OR over all sources that are asserted, globally enabled, unmasked for CPU c, and either private or routed to CPU c as IRQ. Shared source n is asserted through shr_lvl_i[n-N_PCPU].
- R7: fiq_o[c] is the OR over the shared sources that are asserted, globally enabled, unmasked for CPU c, and routed to CPU c as FIQ.
- R8: A read of per-CPU offset 0x044 returns, in bits [9:0], the lowest-numbered source that counts towards irq_o of the calling CPU, or 1023 when there is none. All other bits are 0, and the read leaves the source pending.
- R9: A read of global offset 0x000 returns N_SRC in bits [11:2] and 0 elsewhere.
- R10: Read data appears on rd_data_o with rd_valid_o high in the cycle after the read request. Reads of unmapped offsets return 0. Writes never raise rd_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_win_i | input | 1 | 0 = global window, 1 = per-CPU window |
| req_addr_i | input | 12 | Byte offset inside the window |
| req_wdata_i | input | 32 | Write data |
| req_cpu_i | input | CPU_W | Identifier of the requesting CPU |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| pcpu_lvl_i | input | N_CPU*N_PCPU | Private source lines, one group per CPU |
| shr_lvl_i | input | N_SRC-N_PCPU | Shared source lines |
| irq_o | output | N_CPU | IRQ output per CPU |
| fiq_o | output | N_CPU | FIQ output per CPU |

## Verification
The bench builds the block with its defaults: N_CPU=4, N_SRC=64 and N_PCPU=29. With these values there are 35 shared sources beside the private ones, so both sides of the private/shared boundary can be driven. The 2-bit CPU identifier covers every CPU. Random source numbers reach past 63, which exercises the rule that ignores out-of-range numbers on all four set and clear registers. Four CPUs with independent masks show that a mask write issued by one CPU leaves the other three CPUs untouched.

// File: rtl/dgic_pkg.sv
package dgic_pkg;
  localparam logic [9:0]  SPURIOUS    = 10'd1023;
  localparam int unsigned FIQ_LSB     = 8;
  localparam logic [11:0] OFF_INFO    = 12'h000;
  localparam logic [11:0] OFF_EN_SET  = 12'h030;
  localparam logic [11:0] OFF_EN_CLR  = 12'h034;
  localparam logic [11:0] OFF_ROUTE   = 12'h100;
  localparam logic [11:0] OFF_ACK     = 12'h044;
  localparam logic [11:0] OFF_MSK_SET = 12'h048;
  localparam logic [11:0] OFF_MSK_CLR = 12'h04C;

  typedef enum logic {
    WIN_GLOBAL = 1'b0,
    WIN_CPU    = 1'b1
  } win_e;
endpackage

// File: rtl/dgic_prio.sv
module dgic_prio #(
  parameter int unsigned N  = 64,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // descending scan: the last match, the lowest index, wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dgic_global.sv
module dgic_global #(
  parameter int unsigned N_CPU = 4,
  parameter int unsigned N_SRC = 64,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_set_i,
  input  logic                        en_clr_i,
  input  logic [IDX_W-1:0]            num_i,
  input  logic                        rt_we_i,
  input  logic [IDX_W-1:0]            rt_idx_i,
  input  logic [N_CPU-1:0]            rt_irq_i,
  input  logic [N_CPU-1:0]            rt_fiq_i,
  output logic [N_SRC-1:0]            enable_o,
  output logic [N_SRC-1:0][N_CPU-1:0] route_irq_o,
  output logic [N_SRC-1:0][N_CPU-1:0] route_fiq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o <= '0;
    end else if (en_set_i) begin
      enable_o[num_i] <= 1'b1;
    end else if (en_clr_i) begin
      enable_o[num_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_irq_o <= '0;
      route_fiq_o <= '0;
    end else if (rt_we_i) begin
      route_irq_o[rt_idx_i] <= rt_irq_i;
      route_fiq_o[rt_idx_i] <= rt_fiq_i;
    end
  end
endmodule

// File: rtl/dgic_cpu.sv
module dgic_cpu #(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned N_PCPU = 29,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned N_SHR = N_SRC - N_PCPU
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msk_set_i,
  input  logic              msk_clr_i,
  input  logic [IDX_W-1:0]  num_i,
  input  logic [N_PCPU-1:0] own_lvl_i,
  input  logic [N_SHR-1:0]  shr_lvl_i,
  input  logic [N_SRC-1:0]  enable_i,
  input  logic [N_SHR-1:0]  shr_irq_rt_i,
  input  logic [N_SHR-1:0]  shr_fiq_rt_i,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [9:0]        ack_o
);
  import dgic_pkg::*;

  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] lvl_all, open_all, irq_vec, fiq_vec;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (msk_set_i) begin
      mask_q[num_i] <= 1'b1;
    end else if (msk_clr_i) begin
      mask_q[num_i] <= 1'b0;
    end
  end

  assign lvl_all  = {shr_lvl_i, own_lvl_i};
  assign open_all = lvl_all & enable_i & ~mask_q;
  // private sources ignore routing and never take the FIQ path
  assign irq_vec  = open_all & {shr_irq_rt_i, {N_PCPU{1'b1}}};
  assign fiq_vec  = open_all & {shr_fiq_rt_i, {N_PCPU{1'b0}}};

  assign irq_o = |irq_vec;
  assign fiq_o = |fiq_vec;

  dgic_prio #(.N(N_SRC)) u_prio (
    .vec_i (irq_vec),
    .hit_o (hit),
    .idx_o (hit_idx)
  );

  assign ack_o = hit ? 10'(hit_idx) : SPURIOUS;
endmodule

// File: rtl/dgic_top.sv
module dgic_top #(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned N_PCPU = 29,
  localparam int unsigned CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned N_SHR = N_SRC - N_PCPU
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_write_i,
  input  logic                    req_win_i,
  input  logic [11:0]             req_addr_i,
  input  logic [31:0]             req_wdata_i,
  input  logic [CPU_W-1:0]        req_cpu_i,
  output logic                    rd_valid_o,
  output logic [31:0]             rd_data_o,
  input  logic [N_CPU*N_PCPU-1:0] pcpu_lvl_i,
  input  logic [N_SHR-1:0]        shr_lvl_i,
  output logic [N_CPU-1:0]        irq_o,
  output logic [N_CPU-1:0]        fiq_o
);
  import dgic_pkg::*;

  localparam logic [12:0] ROUTE_END = 13'(256 + 4 * N_SRC);

  logic wr, rd, glb, num_ok, cpu_ok, rt_hit;
  logic [IDX_W-1:0] num, rt_idx;
  logic [11:0] rt_rel;
  logic en_set, en_clr, rt_we;
  logic [N_SRC-1:0] enable;
  logic [N_SRC-1:0][N_CPU-1:0] route_irq, route_fiq;
  logic [N_CPU-1:0][9:0] ack;
  logic [31:0] rdat;

  assign wr     = req_valid_i & req_write_i;
  assign rd     = req_valid_i & ~req_write_i;
  assign glb    = (req_win_i == WIN_GLOBAL);
  assign num_ok = (req_wdata_i < 32'(N_SRC));
  assign num    = req_wdata_i[IDX_W-1:0];

  if (N_CPU == (1 << CPU_W)) begin : g_cpu_full
    assign cpu_ok = 1'b1;
  end else begin : g_cpu_part
    assign cpu_ok = (int'(req_cpu_i) < N_CPU);
  end

  assign rt_rel = req_addr_i - OFF_ROUTE;
  assign rt_hit = (req_addr_i >= OFF_ROUTE) && ({1'b0, req_addr_i} < ROUTE_END)
                  && (req_addr_i[1:0] == 2'b00);
  assign rt_idx = rt_rel[IDX_W+1:2];

  assign en_set = wr & glb & (req_addr_i == OFF_EN_SET) & num_ok;
  assign en_clr = wr & glb & (req_addr_i == OFF_EN_CLR) & num_ok;
  assign rt_we  = wr & glb & rt_hit;

  dgic_global #(.N_CPU(N_CPU), .N_SRC(N_SRC)) u_global (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_set_i    (en_set),
    .en_clr_i    (en_clr),
    .num_i       (num),
    .rt_we_i     (rt_we),
    .rt_idx_i    (rt_idx),
    .rt_irq_i    (req_wdata_i[N_CPU-1:0]),
    .rt_fiq_i    (req_wdata_i[FIQ_LSB +: N_CPU]),
    .enable_o    (enable),
    .route_irq_o (route_irq),
    .route_fiq_o (route_fiq)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [N_SHR-1:0] irq_col, fiq_col;
    logic msk_set, msk_clr, mine;

    for (genvar s = 0; s < N_SHR; s++) begin : g_col
      assign irq_col[s] = route_irq[N_PCPU+s][c];
      assign fiq_col[s] = route_fiq[N_PCPU+s][c];
    end

    assign mine    = wr & ~glb & cpu_ok & num_ok & (req_cpu_i == CPU_W'(c));
    assign msk_set = mine & (req_addr_i == OFF_MSK_SET);
    assign msk_clr = mine & (req_addr_i == OFF_MSK_CLR);

    dgic_cpu #(.N_SRC(N_SRC), .N_PCPU(N_PCPU)) u_cpu (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .msk_set_i    (msk_set),
      .msk_clr_i    (msk_clr),
      .num_i        (num),
      .own_lvl_i    (pcpu_lvl_i[c*N_PCPU +: N_PCPU]),
      .shr_lvl_i    (shr_lvl_i),
      .enable_i     (enable),
      .shr_irq_rt_i (irq_col),
      .shr_fiq_rt_i (fiq_col),
      .irq_o        (irq_o[c]),
      .fiq_o        (fiq_o[c]),
      .ack_o        (ack[c])
    );
  end

  always_comb begin
    rdat = '0;
    if (glb) begin
      if (req_addr_i == OFF_INFO) begin
        rdat[11:2] = 10'(N_SRC);
      end else if (rt_hit) begin
        rdat[N_CPU-1:0]          = route_irq[rt_idx];
        rdat[FIQ_LSB +: N_CPU]   = route_fiq[rt_idx];
      end
    end else if ((req_addr_i == OFF_ACK) && cpu_ok) begin
      rdat[9:0] = ack[req_cpu_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd;
      if (rd) rd_data_o <= rdat;
    end
  end
endmodule

// File: rtl/dgic_chk.sv
module dgic_chk #(
  parameter int unsigned N_CPU = 4,
  parameter int unsigned N_SRC = 64,
  localparam int unsigned CW   = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic             req_win_i,
  input logic [11:0]      req_addr_i,
  input logic [CW-1:0]    req_cpu_i,
  input logic             rd_valid_o,
  input logic [31:0]      rd_data_o,
  input logic [N_CPU-1:0] irq_o,
  input logic [N_CPU-1:0] fiq_o
);
  logic rd_ack_q, rd_irq_q, rd_info_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ack_q  <= 1'b0;
      rd_irq_q  <= 1'b0;
      rd_info_q <= 1'b0;
    end else begin
      rd_ack_q  <= req_valid_i && !req_write_i && req_win_i && (req_addr_i == 12'h044);
      rd_irq_q  <= irq_o[req_cpu_i];
      rd_info_q <= req_valid_i && !req_write_i && !req_win_i && (req_addr_i == 12'h000);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (irq_o == '0 && fiq_o == '0));

  assert_ack_agrees_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ack_q) |-> ((rd_data_o[9:0] != 10'd1023) == rd_irq_q));

  assert_ack_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ack_q) |->
      (rd_data_o[31:10] == '0 && (rd_data_o[9:0] == 10'd1023 || rd_data_o[9:0] < 10'(N_SRC))));

  assert_info_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_info_q) |-> (rd_data_o == (32'(N_SRC) << 2)));

  assert_rd_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rd_valid_o);

  assert_rd_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rd_valid_o);
endmodule

bind dgic_top dgic_chk #(.N_CPU(N_CPU), .N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_win_i   (req_win_i),
  .req_addr_i  (req_addr_i),
  .req_cpu_i   (req_cpu_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o)
);

// File: tb/dgic_top_tb.sv
module dgic_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NS = 64;
  localparam int NP = 29;
  localparam int NH = NS - NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_win = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_cpu = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [NC*NP-1:0] pcpu_lvl = '0;
  logic [NH-1:0] shr_lvl = '0;
  logic [NC-1:0] irq, fiq;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [NS-1:0] en_m;
  logic [NS-1:0] msk_m [NC];
  logic [NC-1:0] ri_m [NS];
  logic [NC-1:0] rf_m [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  dgic_top #(.N_CPU(NC), .N_SRC(NS), .N_PCPU(NP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_win_i(req_win),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_cpu_i(req_cpu),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .pcpu_lvl_i(pcpu_lvl), .shr_lvl_i(shr_lvl),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit elig_irq(int c, int s);
    bit lvl, rt;
    lvl = (s < NP) ? pcpu_lvl[c*NP+s] : shr_lvl[s-NP];
    rt  = (s < NP) ? 1'b1 : ri_m[s][c];
    return lvl && en_m[s] && !msk_m[c][s] && rt;
  endfunction

  function automatic bit elig_fiq(int c, int s);
    if (s < NP) return 1'b0;
    return shr_lvl[s-NP] && en_m[s] && !msk_m[c][s] && rf_m[s][c];
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) if (elig_irq(c, s)) r[c] = 1'b1;
    return r;
  endfunction

  function automatic logic [NC-1:0] exp_fiq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) if (elig_fiq(c, s)) r[c] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_ack(int c);
    for (int s = 0; s < NS; s++) if (elig_irq(c, s)) return 32'(s);
    return 32'd1023;
  endfunction

  function automatic logic [31:0] exp_rd(bit win, logic [11:0] a, int cpu);
    if (!win) begin
      if (a == 12'h000) return 32'(NS) << 2;
      if (a >= 12'h100 && int'(a) < 256 + 4*NS && a[1:0] == 2'b00) begin
        int n = (int'(a) - 256) / 4;
        return {20'd0, rf_m[n], 4'd0, ri_m[n]};
      end
      return 32'd0;
    end
    if (a == 12'h044) return exp_ack(cpu);
    return 32'd0;
  endfunction

  task automatic mdl_wr(bit win, logic [11:0] a, logic [31:0] d, int cpu);
    if (!win) begin
      if (a == 12'h030 && d < NS) en_m[d] = 1'b1;
      if (a == 12'h034 && d < NS) en_m[d] = 1'b0;
      if (a >= 12'h100 && int'(a) < 256 + 4*NS && a[1:0] == 2'b00) begin
        int n = (int'(a) - 256) / 4;
        ri_m[n] = d[NC-1:0];
        rf_m[n] = d[8 +: NC];
      end
    end else begin
      if (a == 12'h048 && d < NS) msk_m[cpu][d] = 1'b1;
      if (a == 12'h04C && d < NS) msk_m[cpu][d] = 1'b0;
    end
  endtask

  task automatic wr(bit win, logic [11:0] a, logic [31:0] d, int cpu);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_win = win; req_addr = a; req_wdata = d; req_cpu = 2'(cpu);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    mdl_wr(win, a, d, cpu);
    #1;
    chk("R10", "rd_valid after write", 32'(rd_valid), 32'd0);
  endtask

  task automatic rd(string req, bit win, logic [11:0] a, int cpu);
    logic [31:0] e;
    @(negedge clk);
    e = exp_rd(win, a, cpu);
    req_valid = 1; req_write = 0; req_win = win; req_addr = a; req_cpu = 2'(cpu);
    @(negedge clk);
    req_valid = 0;
    #1;
    chk("R10", "rd_valid", 32'(rd_valid), 32'd1);
    chk(req, $sformatf("read win=%0d addr=%h cpu=%0d", win, a, cpu), rd_data, e);
  endtask

  task automatic chk_out(string req);
    #1;
    chk(req, "irq_o", 32'(irq), 32'(exp_irq()));
    chk(req, "fiq_o", 32'(fiq), 32'(exp_fiq()));
  endtask

  task automatic set_lvl(logic [NC*NP-1:0] p, logic [NH-1:0] h);
    @(negedge clk);
    pcpu_lvl = p; shr_lvl = h;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    en_m = '0;
    for (int c = 0; c < NC; c++) msk_m[c] = '1;
    for (int s = 0; s < NS; s++) begin ri_m[s] = '0; rf_m[s] = '0; end

    pcpu_lvl = '1; shr_lvl = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all lines high, nothing gets through
    chk_out("R1");
    chk("R1", "irq_o zero", 32'(irq), 32'd0);
    for (int c = 0; c < NC; c++) rd("R1", 1'b1, 12'h044, c);
    rd("R1", 1'b0, 12'h100 + 12'd4*12'd40, 0);
    // R9, R10
    rd("R9", 1'b0, 12'h000, 0);
    rd("R10", 1'b0, 12'h020, 1);
    rd("R10", 1'b1, 12'h040, 2);

    set_lvl('0, '0);
    // R6/R3: shared 40 to cpu2, masked then unmasked
    wr(1'b0, 12'h030, 40, 0);
    wr(1'b0, 12'h100 + 12'd160, 32'h0000_0004, 0);
    set_lvl('0, NH'(1) << (40 - NP));
    chk_out("R3");
    wr(1'b1, 12'h04C, 40, 2);
    chk_out("R6");
    chk("R6", "irq_o cpu2 only", 32'(irq), 32'h4);
    rd("R8", 1'b1, 12'h044, 2);
    rd("R8", 1'b1, 12'h044, 2);
    rd("R3", 1'b1, 12'h044, 1);
    // R2: out-of-range disable ignored, then real disable
    wr(1'b0, 12'h034, 1000, 0);
    wr(1'b0, 12'h034, 32'h0001_0028, 0);
    chk_out("R2");
    chk("R2", "irq_o after bogus clear", 32'(irq), 32'h4);
    wr(1'b0, 12'h034, 40, 0);
    chk_out("R2");
    // R4: readback of all ones
    wr(1'b0, 12'h100 + 12'd4*12'd50, 32'hFFFF_FFFF, 0);
    rd("R4", 1'b0, 12'h100 + 12'd200, 0);
    chk("R4", "route readback", rd_data, 32'h0000_0F0F);
    // R7: shared 50 FIQ to cpu3
    wr(1'b0, 12'h100 + 12'd200, 32'h0000_0800, 0);
    wr(1'b0, 12'h030, 50, 0);
    wr(1'b1, 12'h04C, 50, 3);
    set_lvl('0, NH'(1) << (50 - NP));
    chk_out("R7");
    chk("R7", "fiq_o cpu3", 32'(fiq), 32'h8);
    // R5: private source 5 on cpu1, route bits set but ignored
    wr(1'b0, 12'h100 + 12'd20, 32'h0000_0F0F, 0);
    wr(1'b0, 12'h030, 5, 0);
    wr(1'b1, 12'h04C, 5, 1);
    set_lvl((NC*NP)'(1) << (1*NP + 5) | (NC*NP)'(1) << (0*NP + 5), '0);
    chk_out("R5");
    chk("R5", "irq_o private", 32'(irq), 32'h2);
    // R8: lowest wins; shared 33 also on cpu1
    wr(1'b0, 12'h030, 33, 0);
    wr(1'b1, 12'h04C, 33, 1);
    wr(1'b0, 12'h100 + 12'd132, 32'h0000_0002, 0);
    set_lvl((NC*NP)'(1) << (1*NP + 5), NH'(1) << (33 - NP));
    rd("R8", 1'b1, 12'h044, 1);
    chk("R8", "lowest pending", rd_data, 32'd5);
    set_lvl('0, NH'(1) << (33 - NP));
    rd("R8", 1'b1, 12'h044, 1);
    // R3: out-of-range mask ignored
    wr(1'b1, 12'h048, 64, 1);
    chk_out("R3");

    for (int it = 0; it < 800; it++) begin
      int op = $urandom_range(0, 7);
      int cpu = $urandom_range(0, NC-1);
      int n = $urandom_range(0, 70);
      case (op)
        0: set_lvl({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom});
        1: wr(1'b0, 12'h030, n, cpu);
        2: wr(1'b0, 12'h034, n, cpu);
        3: wr(1'b1, 12'h048, n, cpu);
        4: wr(1'b1, 12'h04C, n, cpu);
        5: wr(1'b0, 12'h100 + 12'(4*(n % NS)), $urandom, cpu);
        6: rd("R8", 1'b1, 12'h044, cpu);
        default: rd("R4", 1'b0, 12'h100 + 12'(4*(n % NS)), cpu);
      endcase
      chk_out("R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule